// File: doc/BRIEF.md
# Two-Channel UART Interrupt Status and Mask Unit

This block is the interrupt unit shared by both channels of a dual UART. Each channel supplies two live level flags: its transmitter can accept data, and its receiver holds data. The unit places these flags into a byte-wide status word, with one four-bit group for each channel. A mask register selects which of them may raise the one active-low interrupt request line.

Status and mask share a single register address. A bus read at that address returns the status word. A bus write at the same address loads the mask, and the mask cannot be read back. The status bits follow their inputs directly and are not latched. A receiver flag therefore drops as soon as the channel's holding data has been taken. The request output is registered, so it follows the masked status with one clock of delay. Counter/timer and input-change events are not part of this unit, and their status positions read as zero.

Top module: `irq_unit`

## Requirements
- R1: While `bus_cs` is 1 and `bus_we` is 0, `bus_rdata` bit 4n equals `tx_rdy[n]` and bit 4n+1 equals `rx_rdy[n]`, in the same cycle, for channels n = 0 and 1.
- R2: Status bits 2, 3, 6 and 7 always read as zero.
- R3: A clock edge with `bus_cs` = 1 and `bus_we` = 1 loads the mask from `bus_wdata`. Mask bit positions match the status bit positions, and bits 2, 3, 6 and 7 are discarded.
- R4: `irq_n` is low in a cycle exactly when the status AND the mask was nonzero at the previous clock edge. It asserts and deasserts one clock after the masked status changes.
- R5: Reset clears the mask and drives `irq_n` high. After reset, no request is made until a mask write enables a bit, even with every ready flag set.
- R6: If the transmitter-ready mask bit is cleared while the transmitter flag stays set, `irq_n` goes high one clock after the mask register updates.
- R7: `bus_rdata` is zero whenever no read is in progress (`bus_cs` = 0, or `bus_we` = 1).
- R8: The mask keeps its value on any edge without a write. This includes bus reads, and writes presented while `bus_cs` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_rdy | input | 2 | Per-channel transmitter-ready flag (bit n = channel n) |
| rx_rdy | input | 2 | Per-channel receiver-ready flag (bit n = channel n) |
| bus_cs | input | 1 | Select of the shared status/mask address |
| bus_we | input | 1 | 1 = write the mask, 0 = read the status |
| bus_wdata | input | 8 | Mask write data |
| bus_rdata | output | 8 | Status read data, zero when not reading |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
On every cycle, the checker confirms four things. Read data matches the channel flags at their fixed positions. The unused positions and idle reads stay zero. The mask changes only on a selected write. The request line equals the inverted masked status from the previous edge. The bench shows what per-cycle properties cannot: all 16 flag patterns crossed with all 16 mask patterns, the exact cycle at which the request rises and falls, the quiet state after reset with every flag set, and the case where a transmitter mask bit is dropped while its flag stays high.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  // Bit position of a channel's transmitter-ready event inside the status word
  function automatic int unsigned tx_pos(int unsigned ch, int unsigned grp_w);
    return ch * grp_w;
  endfunction

  // Bit position of a channel's receiver-ready event inside the status word
  function automatic int unsigned rx_pos(int unsigned ch, int unsigned grp_w);
    return ch * grp_w + 1;
  endfunction
endpackage

// File: rtl/irq_status_gather.sv
module irq_status_gather #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned GROUP_W = 4,
  localparam int unsigned STAT_W = NUM_CH * GROUP_W
) (
  input  logic [NUM_CH-1:0] tx_rdy,
  input  logic [NUM_CH-1:0] rx_rdy,
  output logic [STAT_W-1:0] status
);
  generate
    if (GROUP_W < 2) begin : g_bad_group
      initial $error("GROUP_W must hold at least two events");
    end
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      // live level flags, the upper bits of the group are not sourced here
      assign status[ch*GROUP_W +: GROUP_W] =
        {{(GROUP_W-2){1'b0}}, rx_rdy[ch], tx_rdy[ch]};
    end
  endgenerate
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned GROUP_W = 4,
  localparam int unsigned STAT_W = NUM_CH * GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] mask_q
);
  import irq_unit_pkg::*;

  function automatic logic [STAT_W-1:0] event_bits();
    logic [STAT_W-1:0] v;
    v = '0;
    for (int unsigned ch = 0; ch < NUM_CH; ch++) begin
      v[tx_pos(ch, GROUP_W)] = 1'b1;
      v[rx_pos(ch, GROUP_W)] = 1'b1;
    end
    return v;
  endfunction

  localparam logic [STAT_W-1:0] EVENT_BITS = event_bits();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (wr_stb) mask_q <= wdata & EVENT_BITS;
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] mask,
  output logic              pending,
  output logic              irq_n
);
  logic irq_q;

  assign pending = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending;
  end

  assign irq_n = ~irq_q;
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned GROUP_W = 4,
  localparam int unsigned STAT_W = NUM_CH * GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tx_rdy,
  input  logic [NUM_CH-1:0] rx_rdy,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [STAT_W-1:0] bus_wdata,
  output logic [STAT_W-1:0] bus_rdata,
  output logic              irq_n
);
  logic [STAT_W-1:0] status_vec;
  logic [STAT_W-1:0] mask_q;
  logic              wr_stb;
  logic              rd_stb;
  logic              pending;

  assign wr_stb = bus_cs &  bus_we;
  assign rd_stb = bus_cs & ~bus_we;

  irq_status_gather #(.NUM_CH(NUM_CH), .GROUP_W(GROUP_W)) u_gather (
    .tx_rdy (tx_rdy),
    .rx_rdy (rx_rdy),
    .status (status_vec)
  );

  irq_mask_reg #(.NUM_CH(NUM_CH), .GROUP_W(GROUP_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .wdata  (bus_wdata),
    .mask_q (mask_q)
  );

  irq_req_gen #(.STAT_W(STAT_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status_vec),
    .mask    (mask_q),
    .pending (pending),
    .irq_n   (irq_n)
  );

  assign bus_rdata = rd_stb ? status_vec : '0;
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned GROUP_W = 4,
  localparam int unsigned STAT_W = NUM_CH * GROUP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] tx_rdy,
  input logic [NUM_CH-1:0] rx_rdy,
  input logic              bus_cs,
  input logic              bus_we,
  input logic [STAT_W-1:0] bus_wdata,
  input logic [STAT_W-1:0] bus_rdata,
  input logic              irq_n,
  input logic [STAT_W-1:0] mask_q
);
  logic [STAT_W-1:0] unused_bits;
  logic [STAT_W-1:0] flags_exp;

  always_comb begin
    unused_bits = '1;
    flags_exp   = '0;
    for (int unsigned ch = 0; ch < NUM_CH; ch++) begin
      unused_bits[ch*GROUP_W]     = 1'b0;
      unused_bits[ch*GROUP_W + 1] = 1'b0;
      flags_exp[ch*GROUP_W]       = tx_rdy[ch];
      flags_exp[ch*GROUP_W + 1]   = rx_rdy[ch];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_rd
    AST_READ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && !bus_we) |-> (bus_rdata[ch*GROUP_W] == tx_rdy[ch] &&
                               bus_rdata[ch*GROUP_W+1] == rx_rdy[ch])); // R1
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & unused_bits) == '0); // R2
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_we) |=> mask_q == ($past(bus_wdata) & ~unused_bits)); // R3
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_n == !$past(|(flags_exp & mask_q))); // R4
  AST_QUIET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> irq_n); // R5
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && !bus_we) |-> bus_rdata == '0); // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && bus_we) |=> $stable(mask_q)); // R8
endmodule

bind irq_unit irq_unit_chk #(.NUM_CH(NUM_CH), .GROUP_W(GROUP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_rdy    (tx_rdy),
  .rx_rdy    (rx_rdy),
  .bus_cs    (bus_cs),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_n     (irq_n),
  .mask_q    (mask_q)
);

// File: tb/tb_irq_unit.sv
`timescale 1ns/1ps
module tb_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tx_rdy = '0;
  logic [1:0] rx_rdy = '0;
  logic       bus_cs = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irq_unit dut (
    .clk(clk), .rst_n(rst_n), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
    .bus_cs(bus_cs), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // status word from the flags: channel n has tx at 4n, rx at 4n+1
  function automatic logic [7:0] calc_status(logic [1:0] t, logic [1:0] r);
    logic [7:0] s = '0;
    for (int c = 0; c < 2; c++) s = s | (8'(t[c]) << (4*c)) | (8'(r[c]) << (4*c+1));
    return s;
  endfunction

  task automatic write_mask(input logic [7:0] v);
    @(negedge clk); bus_cs = 1'b1; bus_we = 1'b1; bus_wdata = v;
    @(negedge clk); bus_cs = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic read_check(input string req, input logic [7:0] exp);
    bus_cs = 1'b1; bus_we = 1'b0; #1;
    check(req, bus_rdata, exp);
    bus_cs = 1'b0; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R5: every flag up while in reset and afterwards, with no mask written
    tx_rdy = 2'b11; rx_rdy = 2'b11;
    repeat (3) @(negedge clk);
    check("R5 irq_n in reset", {7'd0, irq_n}, 8'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 irq_n after reset", {7'd0, irq_n}, 8'd1);
    read_check("R1 status after reset", 8'h33);
    check("R7 rdata idle", bus_rdata, 8'h00);

    // R7: no read data while writing (mask write of zero keeps things quiet)
    @(negedge clk); bus_cs = 1'b1; bus_we = 1'b1; bus_wdata = 8'h00; #1;
    check("R7 rdata during write", bus_rdata, 8'h00);
    @(negedge clk); bus_cs = 1'b0; bus_we = 1'b0;

    // R1 R2 R3 R4: sweep every mask pattern against every flag pattern
    for (int m = 0; m < 16; m++) begin
      logic [7:0] mv;
      mv = {2'b11, m[3:2], 2'b11, m[1:0]}; // unused positions set, must be dropped
      write_mask(mv);
      for (int e = 0; e < 16; e++) begin
        logic [7:0] st;
        tx_rdy = {e[2], e[0]}; rx_rdy = {e[3], e[1]};
        st = calc_status(tx_rdy, rx_rdy);
        @(negedge clk);
        check("R4 sweep irq_n", {7'd0, irq_n}, {7'd0, ~|(st & mv & 8'h33)});
        read_check("R1 R2 sweep status", st);
      end
    end

    // R4: exact latency of assert and deassert
    tx_rdy = '0; rx_rdy = '0;
    write_mask(8'h02);
    @(negedge clk);
    check("R4 idle", {7'd0, irq_n}, 8'd1);
    rx_rdy = 2'b01; #1;
    check("R4 no change before edge", {7'd0, irq_n}, 8'd1);
    @(negedge clk);
    check("R4 asserted one clock later", {7'd0, irq_n}, 8'd0);
    rx_rdy = 2'b00; #1;
    check("R4 still low before edge", {7'd0, irq_n}, 8'd0);
    @(negedge clk);
    check("R4 released one clock later", {7'd0, irq_n}, 8'd1);

    // R6: drop the transmitter mask bit while the flag stays up
    write_mask(8'h01);
    tx_rdy = 2'b01;
    @(negedge clk);
    check("R6 tx request", {7'd0, irq_n}, 8'd0);
    write_mask(8'h00);
    check("R6 still low on mask update edge", {7'd0, irq_n}, 8'd0);
    @(negedge clk);
    check("R6 released with tx flag set", {7'd0, irq_n}, 8'd1);
    read_check("R6 tx flag still visible", 8'h01);

    // R8: deselected write and a read with data present leave mask alone
    tx_rdy = 2'b10;
    @(negedge clk); bus_cs = 1'b0; bus_we = 1'b1; bus_wdata = 8'hFF;
    @(negedge clk); bus_cs = 1'b1; bus_we = 1'b0;
    @(negedge clk); bus_cs = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
    @(negedge clk);
    check("R8 mask unchanged", {7'd0, irq_n}, 8'd1);
    write_mask(8'h10);
    @(negedge clk);
    check("R3 channel 1 tx enabled", {7'd0, irq_n}, 8'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule